// File: doc/BRIEF.md
# Task-File PIO Sector Sequencer

This block moves a run of 512-byte sectors between a local sector buffer and a disk device. It does the work through the device's byte-wide task-file registers. A request gives a byte address, a sector count, a direction, the addressing mode (28-bit or 48-bit LBA) and a drive select. A DMA flag swaps in the DMA opcodes. The sequencer first selects the drive. It then splits the run into chunks that never exceed the device's per-interrupt sector limit.

For each chunk the sequencer does the following in order:
- waits for the device to report ready;
- loads the count and address registers in the order the addressing mode demands;
- enables device interrupts and writes the command opcode;
- for PIO, polls busy/error before every sector and then moves exactly 256 sixteen-bit words through the data register.

The sector address advances by the chunk size after each chunk. The block pulses done at the end. Errors and wait timeouts end the request early with an error flag.

The register bus is a simple master port. The sequencer holds a request until the target acknowledges it. Register offsets 0 to 7 are on the command block. Offset 2 of the control block is reached with the control select set.

Top module: `sector_pio_seq`

## Requirements
- R1: At the start of every non-empty request the first access writes the drive select to command offset 6. The value is 0xE0 (drive 0) or 0xF0 (drive 1) in 48-bit mode, and 0xA0 or 0xB0 in 28-bit mode.
- R2: The starting sector number is the byte address divided by 512. Byte address bits 8:0 have no effect.
- R3: In 28-bit mode each chunk writes these registers in this order:
  - command offset 2 ← count bits 7:0;
  - offset 6 ← (0xE0 or 0xF0) OR sector bits 27:24;
  - offsets 3, 4, 5 ← sector bits 7:0, 15:8, 23:16.
- R4: In 48-bit mode each chunk writes these registers in this order:
  - offset 2 ← count bits 15:8;
  - offsets 3, 4, 5 ← sector bits 31:24, 39:32, 47:40;
  - offset 2 ← count bits 7:0;
  - offsets 3, 4, 5 ← sector bits 7:0, 15:8, 23:16.
- R5: After the address load, 0x00 is written to control offset 2, then the opcode to command offset 7. The opcodes, given as 28-bit / 48-bit, are:
  - PIO read 0x20/0x24;
  - PIO write 0x30/0x34;
  - DMA read 0xC8/0x25;
  - DMA write 0xCA/0x35.
- R6: Each chunk holds min(limit, remaining sectors) sectors, where a limit of 0 means 256. The next chunk starts at the previous start plus the chunk size.
- R7: Before each chunk the sequencer repeats status reads at command offset 7 until bit 6 (ready) is 1.
- R8: Before each PIO sector the sequencer repeats status reads until bit 7 (busy) is 0.
  - If bit 0 (error) is then 1, the request ends with error set and no further access.
  - Otherwise exactly 256 word accesses follow at command offset 0. Buffer addresses run from 0 up across the whole request.
  - Reads store each word into the buffer in the acknowledge cycle. Writes send the buffer word at the current buffer address.
- R9: A DMA request issues its opcode and performs no data-register accesses.
- R10: The address warning is set for a request whose byte address is at least 2^37 while 48-bit mode is off. It is clear otherwise, and it holds until the next request.
- R11: A ready or busy wait that has lasted TIMEOUT_CYC cycles ends the request at its next unsatisfied status read, setting both error and timeout.
- R12: done is a one-cycle pulse in the first cycle busy is low after a request. A zero-sector request produces done with no bus access.
- R13: While a bus request is unacknowledged, its direction, select, offset and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start a request (sampled while idle) |
| req_byte_addr | input | ADDR_W | Byte address of the first sector |
| req_sectors | input | CNT_W | Number of sectors |
| req_write | input | 1 | 1 = buffer to device |
| req_lba48 | input | 1 | 1 = 48-bit addressing |
| req_dma | input | 1 | 1 = use DMA opcodes, skip data phase |
| req_slave | input | 1 | Drive select (0 or 1) |
| dev_max_sectors | input | 8 | Device per-interrupt sector limit, 0 = 256 |
| bus_req | output | 1 | Register access pending |
| bus_we | output | 1 | 1 = write |
| bus_ctl | output | 1 | 1 = control block, 0 = command block |
| bus_addr | output | 3 | Register offset |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| buf_addr | output | BUF_AW | Sector buffer word address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer word at buf_addr (same cycle) |
| busy | output | 1 | Request in progress |
| done | output | 1 | End-of-request pulse |
| error | output | 1 | Last request ended on device error or timeout |
| timeout | output | 1 | Last request ended on a wait timeout |
| addr_warn | output | 1 | Address above 28-bit reach without 48-bit mode |

## Verification
The in-RTL assertions check these properties on every cycle:
- bus requests stay steady until acknowledged;
- every write to the command register carries a legal opcode;
- buffer strobes occur only on acknowledged data-register reads;
- DMA requests never touch the data register;
- done is a single pulse with busy low;
- timeout never appears without error, and the warning stays steady through a request.

Register ordering, byte values, chunk boundaries, address advance, the exact word count and the abort points are shown only by the bench scenarios. There, a behavioural device model and an expected-access queue check every completed access against the requirements.

// File: rtl/sector_pio_pkg.sv
package sector_pio_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEL,
        S_RDY,
        S_SETUP,
        S_BSY,
        S_XFER,
        S_ADV,
        S_FIN
    } sp_state_e;

    localparam logic [7:0] SEL28_D0 = 8'hA0;
    localparam logic [7:0] SEL28_D1 = 8'hB0;
    localparam logic [7:0] SEL48_D0 = 8'hE0;
    localparam logic [7:0] SEL48_D1 = 8'hF0;

    localparam logic [7:0] OP_PIO_RD_28 = 8'h20;
    localparam logic [7:0] OP_PIO_RD_48 = 8'h24;
    localparam logic [7:0] OP_PIO_WR_28 = 8'h30;
    localparam logic [7:0] OP_PIO_WR_48 = 8'h34;
    localparam logic [7:0] OP_DMA_RD_28 = 8'hC8;
    localparam logic [7:0] OP_DMA_RD_48 = 8'h25;
    localparam logic [7:0] OP_DMA_WR_28 = 8'hCA;
    localparam logic [7:0] OP_DMA_WR_48 = 8'h35;

    localparam logic [2:0] RG_DATA   = 3'd0;
    localparam logic [2:0] RG_COUNT  = 3'd2;
    localparam logic [2:0] RG_DEVICE = 3'd6;
    localparam logic [2:0] RG_CMD    = 3'd7;

endpackage

// File: rtl/sector_pio_step.sv
// Per-chunk register load list: step index -> (block, offset, byte).
module sector_pio_step
    import sector_pio_pkg::*;
#(
    parameter int LBA_W = 48
) (
    input  logic             lba48,
    input  logic             slave,
    input  logic             wr,
    input  logic             dma,
    input  logic [LBA_W-1:0] lba,
    input  logic [8:0]       chunk,
    input  logic [3:0]       step,
    output logic             st_ctl,
    output logic [2:0]       st_addr,
    output logic [7:0]       st_data,
    output logic             st_last
);
    logic [47:0] lx;
    logic [7:0]  op;
    logic [7:0]  dev28;

    assign lx    = 48'(lba);
    assign dev28 = (slave ? SEL48_D1 : SEL48_D0) | {4'h0, lx[27:24]};

    always_comb begin
        unique case ({dma, wr})
            2'b00:   op = lba48 ? OP_PIO_RD_48 : OP_PIO_RD_28;
            2'b01:   op = lba48 ? OP_PIO_WR_48 : OP_PIO_WR_28;
            2'b10:   op = lba48 ? OP_DMA_RD_48 : OP_DMA_RD_28;
            default: op = lba48 ? OP_DMA_WR_48 : OP_DMA_WR_28;
        endcase
    end

    always_comb begin
        st_ctl  = 1'b0;
        st_addr = RG_CMD;
        st_data = op;
        st_last = 1'b0;
        if (lba48) begin
            unique case (step)
                4'd0:    begin st_addr = RG_COUNT; st_data = {7'd0, chunk[8]}; end
                4'd1:    begin st_addr = 3'd3; st_data = lx[31:24]; end
                4'd2:    begin st_addr = 3'd4; st_data = lx[39:32]; end
                4'd3:    begin st_addr = 3'd5; st_data = lx[47:40]; end
                4'd4:    begin st_addr = RG_COUNT; st_data = chunk[7:0]; end
                4'd5:    begin st_addr = 3'd3; st_data = lx[7:0]; end
                4'd6:    begin st_addr = 3'd4; st_data = lx[15:8]; end
                4'd7:    begin st_addr = 3'd5; st_data = lx[23:16]; end
                4'd8:    begin st_ctl = 1'b1; st_addr = RG_COUNT; st_data = 8'h00; end
                default: st_last = 1'b1;
            endcase
        end else begin
            unique case (step)
                4'd0:    begin st_addr = RG_COUNT; st_data = chunk[7:0]; end
                4'd1:    begin st_addr = RG_DEVICE; st_data = dev28; end
                4'd2:    begin st_addr = 3'd3; st_data = lx[7:0]; end
                4'd3:    begin st_addr = 3'd4; st_data = lx[15:8]; end
                4'd4:    begin st_addr = 3'd5; st_data = lx[23:16]; end
                4'd5:    begin st_ctl = 1'b1; st_addr = RG_COUNT; st_data = 8'h00; end
                default: st_last = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sector_pio_chunk.sv
// Chunk size = min(limit, remaining); limit 0 stands for 256.
module sector_pio_chunk #(
    parameter int CNT_W = 16
) (
    input  logic [7:0]       limit,
    input  logic [CNT_W-1:0] remaining,
    output logic [8:0]       chunk
);
    logic [8:0] lim9;

    assign lim9 = (limit == 8'd0) ? 9'd256 : {1'b0, limit};

    always_comb begin
        if (remaining < CNT_W'(lim9))
            chunk = remaining[8:0];
        else
            chunk = lim9;
    end
endmodule

// File: rtl/sector_pio_timer.sv
// Counts cycles while a wait is in progress; flags when the budget is spent.
module sector_pio_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == TW'(LIMIT));

    always_comb begin
        if (!run)
            cnt_d = '0;
        else if (expired)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sector_pio_seq.sv
module sector_pio_seq
    import sector_pio_pkg::*;
#(
    parameter int ADDR_W      = 57,
    parameter int CNT_W       = 16,
    parameter int BUF_AW      = 11,
    parameter int TIMEOUT_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_byte_addr,
    input  logic [CNT_W-1:0]  req_sectors,
    input  logic              req_write,
    input  logic              req_lba48,
    input  logic              req_dma,
    input  logic              req_slave,
    input  logic [7:0]        dev_max_sectors,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_ctl,
    output logic [2:0]        bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [15:0]       bus_rdata,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_we,
    output logic [15:0]       buf_wdata,
    input  logic [15:0]       buf_rdata,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              timeout,
    output logic              addr_warn
);
    localparam int LBA_W = ADDR_W - 9;
    localparam logic [ADDR_W-1:0] WARN_AT = ADDR_W'(1) << 37;

    typedef struct packed {
        sp_state_e         st;
        logic [LBA_W-1:0]  lba;
        logic [CNT_W-1:0]  left;
        logic [8:0]        chunk;
        logic [8:0]        sec;
        logic [7:0]        word;
        logic [BUF_AW-1:0] bidx;
        logic [3:0]        step;
        logic              wr;
        logic              l48;
        logic              dma;
        logic              slave;
        logic              done;
        logic              err;
        logic              tmo;
        logic              warn;
    } regs_t;

    regs_t r_d, r_q;

    logic       st_ctl, st_last, tmr_run, tmr_exp;
    logic [2:0] st_addr;
    logic [7:0] st_data, sel_byte;
    logic [8:0] chunk_nx;
    logic       unused_low;

    assign unused_low = ^req_byte_addr[8:0];

    sector_pio_step #(.LBA_W(LBA_W)) u_step (
        .lba48(r_q.l48), .slave(r_q.slave), .wr(r_q.wr), .dma(r_q.dma),
        .lba(r_q.lba), .chunk(r_q.chunk), .step(r_q.step),
        .st_ctl(st_ctl), .st_addr(st_addr), .st_data(st_data), .st_last(st_last)
    );

    sector_pio_chunk #(.CNT_W(CNT_W)) u_chunk (
        .limit(dev_max_sectors), .remaining(r_q.left), .chunk(chunk_nx)
    );

    assign tmr_run = (r_q.st == S_RDY) || (r_q.st == S_BSY);

    sector_pio_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(tmr_run), .expired(tmr_exp)
    );

    assign sel_byte = r_q.l48 ? (r_q.slave ? SEL48_D1 : SEL48_D0)
                              : (r_q.slave ? SEL28_D1 : SEL28_D0);

    // Bus drive, decoded from state.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_ctl   = 1'b0;
        bus_addr  = RG_DATA;
        bus_wdata = 16'h0000;
        unique case (r_q.st)
            S_SEL:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = RG_DEVICE; bus_wdata = {8'h00, sel_byte}; end
            S_RDY,
            S_BSY:   begin bus_req = 1'b1; bus_addr = RG_CMD; end
            S_SETUP: begin bus_req = 1'b1; bus_we = 1'b1; bus_ctl = st_ctl; bus_addr = st_addr; bus_wdata = {8'h00, st_data}; end
            S_XFER:  begin bus_req = 1'b1; bus_we = r_q.wr; bus_wdata = r_q.wr ? buf_rdata : 16'h0000; end
            default: ;
        endcase
    end

    assign buf_addr  = r_q.bidx;
    assign buf_we    = (r_q.st == S_XFER) && bus_ack && !r_q.wr;
    assign buf_wdata = bus_rdata;
    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign error     = r_q.err;
    assign timeout   = r_q.tmo;
    assign addr_warn = r_q.warn;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: if (req_valid) begin
                r_d.lba   = req_byte_addr[ADDR_W-1:9];
                r_d.left  = req_sectors;
                r_d.wr    = req_write;
                r_d.l48   = req_lba48;
                r_d.dma   = req_dma;
                r_d.slave = req_slave;
                r_d.warn  = !req_lba48 && (req_byte_addr >= WARN_AT);
                r_d.err   = 1'b0;
                r_d.tmo   = 1'b0;
                r_d.bidx  = '0;
                r_d.st    = (req_sectors == '0) ? S_FIN : S_SEL;
            end
            S_SEL: if (bus_ack) r_d.st = S_RDY;
            S_RDY: if (bus_ack) begin
                if (bus_rdata[6]) begin
                    r_d.chunk = chunk_nx;
                    r_d.step  = 4'd0;
                    r_d.st    = S_SETUP;
                end else if (tmr_exp) begin
                    r_d.err = 1'b1;
                    r_d.tmo = 1'b1;
                    r_d.st  = S_FIN;
                end
            end
            S_SETUP: if (bus_ack) begin
                if (st_last) begin
                    r_d.sec = 9'd0;
                    r_d.st  = r_q.dma ? S_ADV : S_BSY;
                end else begin
                    r_d.step = r_q.step + 4'd1;
                end
            end
            S_BSY: if (bus_ack) begin
                if (!bus_rdata[7]) begin
                    if (bus_rdata[0]) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_FIN;
                    end else begin
                        r_d.word = 8'd0;
                        r_d.st   = S_XFER;
                    end
                end else if (tmr_exp) begin
                    r_d.err = 1'b1;
                    r_d.tmo = 1'b1;
                    r_d.st  = S_FIN;
                end
            end
            S_XFER: if (bus_ack) begin
                r_d.bidx = r_q.bidx + BUF_AW'(1);
                r_d.word = r_q.word + 8'd1;
                if (r_q.word == 8'hFF) begin
                    r_d.sec = r_q.sec + 9'd1;
                    r_d.st  = (r_q.sec + 9'd1 == r_q.chunk) ? S_ADV : S_BSY;
                end
            end
            S_ADV: begin
                r_d.lba  = r_q.lba + LBA_W'(r_q.chunk);
                r_d.left = r_q.left - CNT_W'(r_q.chunk);
                r_d.st   = (r_q.left == CNT_W'(r_q.chunk)) ? S_FIN : S_RDY;
            end
            default: begin
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R13
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_ctl)
                                && $stable(bus_addr) && $stable(bus_wdata));
    // R5
    opcode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && !bus_ctl && bus_addr == RG_CMD |->
            bus_wdata == 16'h20 || bus_wdata == 16'h24 || bus_wdata == 16'h30 ||
            bus_wdata == 16'h34 || bus_wdata == 16'hC8 || bus_wdata == 16'h25 ||
            bus_wdata == 16'hCA || bus_wdata == 16'h35);
    // R8
    buf_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> bus_ack && bus_req && !bus_we && !bus_ctl && bus_addr == RG_DATA);
    // R9
    dma_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.dma && bus_req && !bus_ctl |-> bus_addr != RG_DATA);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy ##1 !done);
    // R11
    timeout_err_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> error);
    // R10
    warn_steady_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(addr_warn));
endmodule

// File: tb/sim_sector_pio_seq.sv
module sim_sector_pio_seq;
    localparam int ADDR_W = 57;
    localparam int CNT_W  = 16;
    localparam int BUF_AW = 11;
    localparam int TMO    = 100;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_byte_addr = '0;
    logic [CNT_W-1:0]  req_sectors = '0;
    logic              req_write = 1'b0, req_lba48 = 1'b0, req_dma = 1'b0, req_slave = 1'b0;
    logic [7:0]        dev_max_sectors = 8'd1;
    logic              bus_req, bus_we, bus_ctl;
    logic [2:0]        bus_addr;
    logic [15:0]       bus_wdata;
    logic              bus_ack = 1'b0;
    logic [15:0]       bus_rdata = 16'h0;
    logic [BUF_AW-1:0] buf_addr;
    logic              buf_we;
    logic [15:0]       buf_wdata, buf_rdata;
    logic              busy, done, error, timeout, addr_warn;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 3 + 16'h5A);
    endfunction

    assign buf_rdata = pat(int'(buf_addr));

    sector_pio_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_AW(BUF_AW), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_byte_addr(req_byte_addr),
        .req_sectors(req_sectors), .req_write(req_write), .req_lba48(req_lba48),
        .req_dma(req_dma), .req_slave(req_slave), .dev_max_sectors(dev_max_sectors),
        .bus_req(bus_req), .bus_we(bus_we), .bus_ctl(bus_ctl), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .error(error), .timeout(timeout), .addr_warn(addr_warn)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected non-status accesses: {we, ctl, addr[2:0], data[15:0]}
    logic [20:0] expq[$];
    string       cur_tag = "";
    int          rdy_delay = 0, busy_left = 0, dcnt = 0;
    bit          never_rdy = 0, err_data = 0;
    logic [15:0] rmem [0:2047];
    bit          hold_pend = 0;
    logic [20:0] hold_val;
    int          lat = 0;

    task automatic push(input bit we, input bit ctl, input int a, input int d);
        expq.push_back({we, ctl, 3'(a), 16'(d)});
    endtask

    // mode 0: full run, 1: stop after first command, 2: stop after select
    task automatic build(input logic [47:0] lba0, input int cnt, input bit wr, input bit l48,
                         input bit dma, input bit slave, input int lim, input int mode);
        logic [47:0] lba = lba0;
        int left = cnt, widx = 0, lm = (lim == 0) ? 256 : lim;
        int op;
        push(1, 0, 6, l48 ? (slave ? 'hF0 : 'hE0) : (slave ? 'hB0 : 'hA0));
        if (mode == 2) return;
        if (l48) op = dma ? (wr ? 'h35 : 'h25) : (wr ? 'h34 : 'h24);
        else     op = dma ? (wr ? 'hCA : 'hC8) : (wr ? 'h30 : 'h20);
        while (left > 0) begin
            int ch = (left < lm) ? left : lm;
            if (l48) begin
                push(1, 0, 2, ch >> 8); push(1, 0, 3, lba[31:24]);
                push(1, 0, 4, lba[39:32]); push(1, 0, 5, lba[47:40]);
                push(1, 0, 2, ch & 'hFF); push(1, 0, 3, lba[7:0]);
                push(1, 0, 4, lba[15:8]); push(1, 0, 5, lba[23:16]);
            end else begin
                push(1, 0, 2, ch & 'hFF);
                push(1, 0, 6, (slave ? 'hF0 : 'hE0) | lba[27:24]);
                push(1, 0, 3, lba[7:0]); push(1, 0, 4, lba[15:8]); push(1, 0, 5, lba[23:16]);
            end
            push(1, 1, 2, 0);
            push(1, 0, 7, op);
            if (mode == 1) return;
            if (!dma) begin
                for (int s = 0; s < ch * 256; s++) begin
                    push(wr, 0, 0, wr ? int'(pat(widx)) : 0);
                    widx++;
                end
            end
            lba  = lba + 48'(ch);
            left = left - ch;
        end
    endtask

    task automatic serve();
        logic [20:0] e;
        if (!bus_we && !bus_ctl && bus_addr == 3'd7) begin
            if (never_rdy) bus_rdata = 16'h0080;
            else if (busy_left > 0) begin busy_left--; bus_rdata = 16'h0080; end
            else if (err_data) bus_rdata = 16'h0041;
            else bus_rdata = 16'h0058;
            return;
        end
        if (expq.size() == 0) begin
            chk(0, {cur_tag, " unexpected access"}, {bus_we, bus_ctl, bus_addr, bus_wdata}, 0);
        end else begin
            e = expq.pop_front();
            if (e[20])
                chk({bus_we, bus_ctl, bus_addr, bus_wdata} == e, {cur_tag, " access"},
                    {bus_we, bus_ctl, bus_addr, bus_wdata}, e);
            else
                chk({bus_we, bus_ctl, bus_addr} == e[20:16], {cur_tag, " access"},
                    {bus_we, bus_ctl, bus_addr}, e[20:16]);
        end
        if (bus_we && !bus_ctl && bus_addr == 3'd7) busy_left = rdy_delay;
        if (!bus_we && !bus_ctl && bus_addr == 3'd0) begin
            bus_rdata = 16'hA000 ^ 16'(dcnt);
            #1;
            chk(buf_we == 1'b1 && buf_wdata == (16'hA000 ^ 16'(dcnt)), "R8 buffer strobe",
                {buf_we, buf_wdata}, {1'b1, 16'hA000 ^ 16'(dcnt)});
            if (buf_we) rmem[buf_addr] = buf_wdata;
            dcnt++;
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0; lat = 0; hold_pend = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0; lat = 0;
        end else if (bus_req) begin
            if (hold_pend)
                chk({bus_we, bus_ctl, bus_addr, bus_wdata} == hold_val, "R13 hold",
                    {bus_we, bus_ctl, bus_addr, bus_wdata}, hold_val);
            if (lat == 0) begin
                lat = 1; hold_pend = 1;
                hold_val = {bus_we, bus_ctl, bus_addr, bus_wdata};
            end else begin
                bus_ack = 1'b1; hold_pend = 0;
                serve();
            end
        end else begin
            hold_pend = 0;
        end
    end

    task automatic run(input string tag, input logic [ADDR_W-1:0] ba, input int cnt, input bit wr,
                       input bit l48, input bit dma, input bit slave, input int lim,
                       input bit e_err, input bit e_tmo, input bit e_warn, input bit chk_data);
        int k = 0, bad = 0;
        cur_tag = tag;
        dcnt = 0;
        busy_left = rdy_delay;
        for (int i = 0; i < 2048; i++) rmem[i] = 16'hDEAD;
        @(negedge clk);
        req_byte_addr = ba; req_sectors = CNT_W'(cnt); req_write = wr; req_lba48 = l48;
        req_dma = dma; req_slave = slave; dev_max_sectors = 8'(lim); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {tag, " R12 busy after accept"}, busy, 1);
        while (!done && k < 100000) begin @(negedge clk); k++; end
        chk(done == 1'b1 && busy == 1'b0, {tag, " R12 done pulse"}, {done, busy}, 2'b10);
        chk(error == e_err, {tag, " R8 R11 error"}, error, e_err);
        chk(timeout == e_tmo, {tag, " R11 timeout"}, timeout, e_tmo);
        chk(addr_warn == e_warn, {tag, " R10 warn"}, addr_warn, e_warn);
        chk(expq.size() == 0, {tag, " all accesses seen"}, expq.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R12 single pulse"}, done, 0);
        if (chk_data) begin
            for (int i = 0; i < cnt * 256; i++)
                if (rmem[i] !== (16'hA000 ^ 16'(i))) bad++;
            chk(bad == 0, {tag, " R8 buffer contents"}, bad, 0);
        end
        expq.delete();
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [ADDR_W-1:0] ba;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && bus_req == 0 && error == 0 && timeout == 0,
            "R12 reset state", {busy, done, bus_req, error, timeout}, 0);

        // R1 R2 R3 R6 R7 R8: 28-bit read, low bits set, chunks 2,2,1
        rdy_delay = 2;
        ba = ADDR_W'(64'h1234_5600) | ADDR_W'(9'h1FF);
        build(48'(64'h1234_5600 >> 9), 5, 0, 0, 0, 0, 2, 0);
        run("R3 lba28 read", ba, 5, 0, 0, 0, 0, 2, 0, 0, 0, 1);

        // R4 R8: 48-bit write, drive 1, single chunk of 3
        rdy_delay = 1;
        ba = ADDR_W'(48'h0A0B_0C0D_0E0F) << 9;
        build(48'h0A0B_0C0D_0E0F, 3, 1, 1, 0, 1, 8, 0);
        run("R4 lba48 write", ba, 3, 1, 1, 0, 1, 8, 0, 0, 0, 0);

        // R10 R6: high address without 48-bit mode, limit 0
        rdy_delay = 0;
        ba = (ADDR_W'(1) << 37) + ADDR_W'(5 * 512);
        build(48'((64'h1 << 28) + 5), 1, 0, 0, 0, 0, 0, 0);
        run("R10 warn lba28", ba, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1);

        // R10 R6: high address in 48-bit mode, chunks of 1
        ba = ADDR_W'(48'h0000_2000_0003) << 9;
        build(48'h0000_2000_0003, 2, 0, 1, 0, 0, 1, 0);
        run("R6 lba48 chunks", ba, 2, 0, 1, 0, 0, 1, 0, 0, 0, 1);

        // R9 R5: DMA opcodes, no data phase
        ba = ADDR_W'(48'h77) << 9;
        build(48'h77, 4, 0, 1, 1, 0, 3, 0);
        run("R9 dma read", ba, 4, 0, 1, 1, 0, 3, 0, 0, 0, 0);
        build(48'h90, 2, 1, 0, 1, 1, 2, 0);
        run("R9 dma write", ADDR_W'(48'h90) << 9, 2, 1, 0, 1, 1, 2, 0, 0, 0, 0);

        // R8: device error before first sector
        rdy_delay = 2; err_data = 1;
        build(48'h40, 2, 0, 0, 0, 0, 2, 1);
        run("R8 device error", ADDR_W'(48'h40) << 9, 2, 0, 0, 0, 0, 2, 1, 0, 0, 0);
        err_data = 0;

        // R11: device never ready
        never_rdy = 1;
        build(48'h10, 1, 0, 0, 0, 0, 1, 2);
        run("R11 timeout", ADDR_W'(48'h10) << 9, 1, 0, 0, 0, 0, 1, 1, 1, 0, 0);
        never_rdy = 0;

        // R12: zero sectors
        run("R12 zero count", ADDR_W'(48'h20) << 9, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule